// File: doc/BRIEF.md
# Receive FIFO Idle Timeout Interrupt

This block raises an interrupt when data has sat in a serial port's receive FIFO for a fixed number of serial bit periods with no new entry arriving. It does not hold the FIFO. It sees four things: a one-cycle tick per serial bit period, a strobe for each FIFO write, the FIFO's empty flag, and a write-one-to-clear strobe from the interrupt-clear register. It keeps a raw status bit and ANDs it with a software mask bit to drive the interrupt line.

While the FIFO holds data and no new entry arrives, a countdown runs on the bit tick. When the countdown reaches zero, the raw bit is set. Each new entry reloads the countdown. Draining the FIFO clears the raw bit, and so does the software clear. If the raw bit is cleared while entries remain, a fresh full-length countdown starts, so the interrupt comes back unless software reads the data.

Top module: `rx_idle_timeout`

## Requirements
- R1: After reset, `raw_stat` and `irq` are 0 and the countdown holds its full length of `TICKS` bit periods (default 32).
- R2: A cycle with `fifo_wr`=1 reloads the countdown to its full length. `raw_stat` then rises only after `TICKS` further bit ticks with no write.
- R3: While the FIFO is non-empty, `raw_stat` goes to 1 on the clock edge that follows the cycle holding the `TICKS`-th `bit_tick` since the last reload. After `TICKS`-1 such ticks it is still 0.
- R4: A cycle with `clr_w1c`=1 and no expiry clears `raw_stat` to 0 on the next edge.
- R5: While `fifo_empty`=1, `raw_stat` is 0 from the next edge onward.
- R6: While `fifo_empty`=1, bit ticks have no effect. The countdown stays at full length, so after the first write a full `TICKS` ticks are still needed.
- R7: With the default `IRQ_REG`=0, `irq` equals `raw_stat` AND `mask_en` in every cycle. With `mask_en`=0, `irq` is 0.
- R8: After an expiry, a clear while the FIFO still holds data starts a fresh `TICKS`-tick countdown, and `raw_stat` is set again when it runs out.
- R9: If the expiring tick and `clr_w1c` fall in the same cycle, `raw_stat` is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| fifo_wr | input | 1 | A new entry is written to the receive FIFO this cycle |
| fifo_empty | input | 1 | Receive FIFO holds no entries |
| clr_w1c | input | 1 | Software write of 1 to the timeout clear bit |
| mask_en | input | 1 | Interrupt enable mask |
| raw_stat | output | 1 | Raw timeout status |
| irq | output | 1 | Masked timeout interrupt |

## Verification
Two events can land in the same cycle: the tick that takes the countdown to zero and a software clear. The bench provokes this by steering the tick by hand. It issues `TICKS`-1 ticks after a write, then drives the final tick together with `clr_w1c`, and expects `raw_stat` to read 1 after that edge. A second pairing is a write arriving between ticks while a countdown is part-way through. That case is judged by the restarted count needing a full `TICKS` ticks. A behavioural reference model is compared with both outputs on every cycle.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
   function automatic int unsigned cnt_width(input int unsigned ticks);
      return $clog2(ticks + 1);
   endfunction
endpackage

// File: rtl/rxto_countdown.sv
module rxto_countdown #(
   parameter int unsigned TICKS = 32,
   parameter int unsigned CNT_W = rxto_pkg::cnt_width(TICKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_tick,
   input  logic             fifo_wr,
   input  logic             fifo_empty,
   input  logic             clr_w1c,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(TICKS);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic reload;
   logic at_zero;

   assign at_zero = (cnt == '0);
   // the last tick of a count with data present and no refresh
   assign expire  = bit_tick && (cnt == ONE) && !fifo_wr && !fifo_empty;
   // empty holds full length, a write refreshes, a clear after expiry re-arms
   assign reload  = fifo_empty || fifo_wr || (clr_w1c && at_zero);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= FULL;
      end else if (reload) begin
         cnt <= FULL;
      end else if (bit_tick && !at_zero) begin
         cnt <= cnt - ONE;
      end
   end
endmodule

// File: rtl/rxto_status.sv
module rxto_status (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic clr_w1c,
   input  logic fifo_empty,
   output logic raw_stat
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_stat <= 1'b0;
      end else if (expire) begin
         raw_stat <= 1'b1;
      end else if (clr_w1c || fifo_empty) begin
         raw_stat <= 1'b0;
      end
   end
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout #(
   parameter int unsigned TICKS   = 32,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic fifo_wr,
   input  logic fifo_empty,
   input  logic clr_w1c,
   input  logic mask_en,
   output logic raw_stat,
   output logic irq
);
   localparam int unsigned CNT_W = rxto_pkg::cnt_width(TICKS);

   initial begin
      if (TICKS < 2) $error("rx_idle_timeout: TICKS must be at least 2");
   end

   logic [CNT_W-1:0] cnt;
   logic             expire;

   rxto_countdown #(.TICKS(TICKS), .CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fifo_wr(fifo_wr),
      .fifo_empty(fifo_empty), .clr_w1c(clr_w1c), .cnt(cnt), .expire(expire)
   );

   rxto_status u_stat (
      .clk(clk), .rst_n(rst_n), .expire(expire), .clr_w1c(clr_w1c),
      .fifo_empty(fifo_empty), .raw_stat(raw_stat)
   );

   generate
      if (IRQ_REG) begin : g_irq_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= raw_stat && mask_en;
         end
      end else begin : g_irq_comb
         assign irq = raw_stat && mask_en;
      end
   endgenerate
endmodule

// File: rtl/rxto_chk.sv
module rxto_chk #(
   parameter int unsigned TICKS = 32,
   parameter int unsigned CNT_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fifo_wr,
   input logic             fifo_empty,
   input logic             clr_w1c,
   input logic             mask_en,
   input logic             raw_stat,
   input logic             irq,
   input logic [CNT_W-1:0] cnt,
   input logic             expire
);
   // R1: counter starts full (checked right after reset release)
   a_r1_reset_full: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cnt == CNT_W'(TICKS)));
   // R2: a write reloads the count
   a_r2_write_reload: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr |=> (cnt == CNT_W'(TICKS)));
   // R3: status rises only after an expiry
   a_r3_rise_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_stat) |-> $past(expire));
   a_r3_set_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> raw_stat);
   // R4: clear without expiry drops the status
   a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_w1c && !expire) |=> !raw_stat);
   // R5: empty FIFO drops the status
   a_r5_empty_clears: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty |=> !raw_stat);
   // R6: count held full while empty
   a_r6_hold_empty: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty |=> (cnt == CNT_W'(TICKS)));
   // R7: masked line stays low when disabled
   a_r7_mask_low: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_en |-> !irq);
   // R9: expiry wins over a clear in the same cycle
   a_r9_expire_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && clr_w1c) |=> raw_stat);
endmodule

bind rx_idle_timeout rxto_chk #(.TICKS(TICKS), .CNT_W(CNT_W)) u_rxto_chk (
   .clk(clk), .rst_n(rst_n), .fifo_wr(fifo_wr), .fifo_empty(fifo_empty),
   .clr_w1c(clr_w1c), .mask_en(mask_en), .raw_stat(raw_stat), .irq(irq),
   .cnt(cnt), .expire(expire)
);

// File: tb/rx_idle_timeout_tb.sv
module rx_idle_timeout_tb_top;
   localparam int TICKS = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_tick = 1'b0, fifo_wr = 1'b0, rd = 1'b0, clr_w1c = 1'b0, mask_en = 1'b0;
   logic fifo_empty;
   logic raw_stat, irq;

   int occ;
   int m_cnt;
   logic m_raw;
   int n_chk = 0, n_fail = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   assign fifo_empty = (occ == 0);

   rx_idle_timeout #(.TICKS(TICKS)) dut_i (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fifo_wr(fifo_wr),
      .fifo_empty(fifo_empty), .clr_w1c(clr_w1c), .mask_en(mask_en),
      .raw_stat(raw_stat), .irq(irq)
   );

   // behavioural reference: remaining ticks, status, FIFO occupancy
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt <= TICKS; m_raw <= 1'b0; occ <= 0;
      end else begin
         bit fire;
         fire = bit_tick && m_cnt == 1 && !fifo_wr && occ != 0;
         if (occ == 0 || fifo_wr)         m_cnt <= TICKS;
         else if (clr_w1c && m_cnt == 0)  m_cnt <= TICKS;
         else if (bit_tick && m_cnt > 0)  m_cnt <= m_cnt - 1;
         if (fire)                        m_raw <= 1'b1;
         else if (clr_w1c || occ == 0)    m_raw <= 1'b0;
         occ <= occ + (fifo_wr ? 1 : 0) - ((rd && occ > 0) ? 1 : 0);
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic compare();
      chk(raw_stat === m_raw, cur_req, "raw_stat vs model", int'(raw_stat), int'(m_raw));
      chk(irq === (m_raw && mask_en), "R7", "irq vs model", int'(irq), int'(m_raw && mask_en));
   endtask

   task automatic step(input logic t, input logic w, input logic r, input logic c);
      bit_tick = t; fifo_wr = w; rd = r; clr_w1c = c;
      @(negedge clk);
      compare();
      bit_tick = 1'b0; fifo_wr = 1'b0; rd = 1'b0; clr_w1c = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         step(1'b1, 1'b0, 1'b0, 1'b0);
         step(1'b0, 1'b0, 1'b0, 1'b0);
         step(1'b0, 1'b0, 1'b0, 1'b0);
      end
   endtask

   task automatic report();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      cur_req = "R1";
      chk(raw_stat == 1'b0, "R1", "raw after reset", int'(raw_stat), 0);
      chk(irq == 1'b0, "R1", "irq after reset", int'(irq), 0);
      rst_n = 1'b1;
      @(negedge clk);
      compare();

      // R6: ticks while empty are ignored
      cur_req = "R6";
      ticks(40);
      chk(raw_stat == 1'b0, "R6", "raw while empty", int'(raw_stat), 0);
      step(1'b0, 1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b0);
      // R3: exact expiry tick, full count needed (R1, R6)
      cur_req = "R3";
      ticks(TICKS - 1);
      chk(raw_stat == 1'b0, "R3", "raw one tick early", int'(raw_stat), 0);
      step(1'b1, 1'b0, 1'b0, 1'b0);
      chk(raw_stat == 1'b1, "R3", "raw at expiry", int'(raw_stat), 1);
      ticks(5);
      chk(raw_stat == 1'b1, "R3", "raw stays set", int'(raw_stat), 1);

      // R7: mask
      cur_req = "R7";
      chk(irq == 1'b0, "R7", "irq masked", int'(irq), 0);
      mask_en = 1'b1;
      @(negedge clk); compare();
      chk(irq == 1'b1, "R7", "irq unmasked", int'(irq), 1);

      // R4 + R8: clear with data left restarts a full count
      cur_req = "R4";
      step(1'b0, 1'b0, 1'b0, 1'b1);
      chk(raw_stat == 1'b0, "R4", "raw after clear", int'(raw_stat), 0);
      cur_req = "R8";
      ticks(TICKS - 1);
      chk(raw_stat == 1'b0, "R8", "raw before re-expiry", int'(raw_stat), 0);
      step(1'b1, 1'b0, 1'b0, 1'b0);
      chk(raw_stat == 1'b1, "R8", "raw after re-expiry", int'(raw_stat), 1);

      // R2: a write mid-count restarts it
      cur_req = "R2";
      step(1'b0, 1'b0, 1'b0, 1'b1);
      ticks(20);
      step(1'b0, 1'b1, 1'b0, 1'b0);
      ticks(TICKS - 1);
      chk(raw_stat == 1'b0, "R2", "raw after write refresh", int'(raw_stat), 0);
      step(1'b1, 1'b0, 1'b0, 1'b0);
      chk(raw_stat == 1'b1, "R2", "raw after full count", int'(raw_stat), 1);

      // R5: draining clears
      cur_req = "R5";
      for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b0);
      chk(raw_stat == 1'b0, "R5", "raw after drain", int'(raw_stat), 0);
      chk(fifo_empty == 1'b1, "R5", "fifo drained", int'(fifo_empty), 1);

      // R9: expiry and clear in the same cycle
      cur_req = "R9";
      step(1'b0, 1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b0);
      ticks(TICKS - 1);
      step(1'b1, 1'b0, 1'b0, 1'b1);
      chk(raw_stat == 1'b1, "R9", "expiry beats clear", int'(raw_stat), 1);
      chk(irq == 1'b1, "R9", "irq after tie", int'(irq), 1);

      done = 1'b1;
      report();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual=running expected=done");
         report();
      end
   end
endmodule